// File: doc/BRIEF.md
# Independent Watchdog Timer

This block is a watchdog that keeps counting on a slow time base of its own. A bus clock `clk` runs the logic. The slow clock arrives as the single-cycle enable `slow_tick`, which is synchronous to `clk`. A 12-bit down counter steps once per prescaled period. When the counter expires, the block raises a reset request. Once the watchdog is running, software must refresh it before that happens.

Software uses a small register port. Key words written to the control address unlock the configuration, refresh the counter or start the watchdog. Any other control write locks the configuration again. A new prescaler or reload value takes effect in the counting logic only after a fixed number of slow ticks, and a status flag for each register shows that the update is still pending. If the processor is halted while debug hold is set, counting stops.

Top module: `ind_watchdog`

## Requirements
- R1: After reset the prescaler select reads 0, the reload value reads 0xFFF, the status reads 0, the counter is idle and `rst_req` stays low.
- R2: While the configuration is locked, writes to the prescaler (address 1) and reload (address 2) registers leave their values unchanged.
- R3: Writing 0x5555 to the control register (address 0) unlocks it. A later prescaler or reload write then updates the value read back, using bits [2:0] and [11:0] respectively.
- R4: Writing the refresh key 0xAAAA reloads the counter from the effective reload value, clears the prescaler phase, and locks the configuration.
- R5: A control write of any value other than 0x5555 locks the configuration.
- R6: The start key 0xCCCC starts counting from the effective reload value. Expiries then repeat every (reload+1) × divider slow ticks. Prescaler codes 0 to 6 divide by 4 << code, and code 7 divides by 256.
- R7: Each expiry produces a `rst_req` pulse exactly one `clk` cycle wide.
- R8: Refresh writes that arrive more often than the timeout period prevent any expiry.
- R9: Once started, the watchdog keeps running. No control write stops it; only reset does.
- R10: While `dbg_hold` and `cpu_halted` are both high, the counter does not advance. `dbg_hold` on its own has no effect.
- R11: Status bit 0 (prescaler) or bit 1 (reload) at address 3 is set by an accepted write. It clears after SYNC_TICKS slow ticks, and at that point the new value takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset |
| slow_tick | input | 1 | One-cycle enable marking each slow clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 prescaler, 2 reload, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (control reads 0) |
| dbg_hold | input | 1 | Freeze the counter while the processor is halted |
| cpu_halted | input | 1 | Processor halted in debug |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The expiry interval is measured between consecutive pulses, so that the slow-tick phase drops out. It is measured for prescaler codes 0, 2 and 7 and for the reset configuration. These cases separate the shift law, the saturation of code 7 and the (reload+1) count. Register writes are tried while locked, after an unlock, after a refresh key and after a stray key, which separates the lock paths. Refreshes at a rate below the timeout show that they restart the count, and stray control writes show that they do not stop it. Debug hold is tried both with and without a halted processor.

// File: rtl/ind_watchdog.sv
module ind_watchdog #(
  parameter int CW         = 12,
  parameter int SYNC_TICKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        dbg_hold,
  input  logic        cpu_halted,
  output logic        rst_req
);
  localparam logic [15:0] KEY_UNLOCK = 16'h5555;
  localparam logic [15:0] KEY_FEED   = 16'hAAAA;
  localparam logic [15:0] KEY_START  = 16'hCCCC;
  localparam int SW = $clog2(SYNC_TICKS + 1);

  logic          unlocked, running;
  logic [2:0]    psc_reg, psc_eff;
  logic [CW-1:0] rld_reg, rld_eff, count;
  logic [SW-1:0] psc_sync, rld_sync;
  logic [7:0]    prediv;

  wire ctrl_wr   = wr_en && addr == 2'd0;
  wire psc_wr    = wr_en && addr == 2'd1 && unlocked;
  wire rld_wr    = wr_en && addr == 2'd2 && unlocked;
  wire key_feed  = ctrl_wr && wdata == KEY_FEED;
  wire key_start = ctrl_wr && wdata == KEY_START;
  wire load      = key_feed || (key_start && !running);

  wire [2:0] shift  = (psc_eff == 3'd7) ? 3'd6 : psc_eff;
  wire [8:0] div    = 9'd4 << shift;
  wire [7:0] div_m1 = 8'(div - 9'd1);

  wire step   = running && slow_tick && !(dbg_hold && cpu_halted);
  wire wrap   = step && prediv == div_m1;
  wire expire = wrap && count == '0;

  always_comb begin
    case (addr)
      2'd1:    rdata = 16'(psc_reg);
      2'd2:    rdata = 16'(rld_reg);
      2'd3:    rdata = {14'd0, rld_sync != '0, psc_sync != '0};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      running  <= 1'b0;
      psc_reg  <= '0;
      psc_eff  <= '0;
      psc_sync <= '0;
      rld_reg  <= '1;
      rld_eff  <= '1;
      rld_sync <= '0;
      count    <= '1;
      prediv   <= '0;
      rst_req  <= 1'b0;
    end else begin
      if (ctrl_wr) unlocked <= (wdata == KEY_UNLOCK);
      if (key_start) running <= 1'b1;

      if (psc_wr) begin
        psc_reg  <= wdata[2:0];
        psc_sync <= SW'(SYNC_TICKS);
      end else if (slow_tick && psc_sync != '0) begin
        psc_sync <= psc_sync - 1'b1;
        if (psc_sync == SW'(1)) psc_eff <= psc_reg;
      end

      if (rld_wr) begin
        rld_reg  <= wdata[CW-1:0];
        rld_sync <= SW'(SYNC_TICKS);
      end else if (slow_tick && rld_sync != '0) begin
        rld_sync <= rld_sync - 1'b1;
        if (rld_sync == SW'(1)) rld_eff <= rld_reg;
      end

      if (load) begin
        count  <= rld_eff;
        prediv <= '0;
      end else if (wrap) begin
        prediv <= '0;
        count  <= (count == '0) ? rld_eff : count - 1'b1;
      end else if (step) begin
        prediv <= prediv + 1'b1;
      end

      rst_req <= expire;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rst_req);                                          // R1
  AST_LOCKED_PSC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && !unlocked) |=> $stable(psc_reg));       // R2
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);                                           // R7
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);                                            // R9
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_hold && cpu_halted && !ctrl_wr) |=> $stable(count) && $stable(prediv)); // R10
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    psc_wr |=> rdata[0] || addr != 2'd3 || psc_sync != '0);          // R11
endmodule

// File: tb/ind_watchdog_bench.sv
module ind_watchdog_bench;
  logic        clk = 0, rst_n = 0, slow_tick = 0, wr_en = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        dbg_hold = 0, cpu_halted = 0, rst_req;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, npulse = 0, last_t = 0, prev_t = 0, width_err = 0;
  logic prev_high = 0;

  localparam int TP = 2;

  ind_watchdog u_ind_watchdog (.*);

  always #4 clk = ~clk;
  initial forever @(negedge clk) slow_tick = ~slow_tick;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (rst_req) begin
      if (prev_high) width_err <= width_err + 1;
      npulse <= npulse + 1;
      prev_t <= last_t;
      last_t <= cyc;
    end
    prev_high <= rst_req;
  end

  always @(posedge clk) if (cyc > 190000) begin
    n_bad++;
    $display("FAIL R0 watchdog expired actual=%0d expected<190000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; dbg_hold = 0; cpu_halted = 0;
    idle(3);
    rst_n = 1;
    idle(2);
  endtask

  task automatic setup(int p, int r);
    wr(0, 16'h5555); wr(1, 16'(p)); wr(2, 16'(r)); wr(0, 16'h0000);
    idle(12);
  endtask

  function automatic int period(int p, int r);
    int sh = (p == 7) ? 6 : p;
    return (r + 1) * (4 << sh) * TP;
  endfunction

  task automatic measure(output int iv);
    int base = npulse;
    int n = 0;
    while (npulse < base + 2 && n < 80000) begin @(negedge clk); n++; end
    iv = last_t - prev_t;
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    rd(1, v); chk("R1 psc", v, 0);
    rd(2, v); chk("R1 rld", v, 12'hFFF);
    rd(3, v); chk("R1 status", v, 0);
    v = npulse; idle(200); chk("R1 idle no pulse", npulse - v, 0);
  endtask

  task automatic t_locks();
    int v;
    do_reset();
    wr(1, 16'h5); rd(1, v); chk("R2 locked psc", v, 0);
    wr(2, 16'h123); rd(2, v); chk("R2 locked rld", v, 12'hFFF);
    wr(0, 16'h5555); wr(1, 16'h6); rd(1, v); chk("R3 unlocked psc", v, 6);
    wr(2, 16'h0AB); rd(2, v); chk("R3 unlocked rld", v, 12'h0AB);
    wr(0, 16'hAAAA); wr(1, 16'h2); rd(1, v); chk("R4 feed relocks", v, 6);
    wr(0, 16'h5555); wr(0, 16'h1234); wr(2, 16'h7); rd(2, v); chk("R5 stray key locks", v, 12'h0AB);
  endtask

  task automatic t_busy();
    int v;
    do_reset();
    wr(0, 16'h5555); wr(1, 16'h3);
    rd(3, v); chk("R11 psc busy set", v, 1);
    idle(8); rd(3, v); chk("R11 psc busy clear", v, 0);
    wr(2, 16'h9);
    rd(3, v); chk("R11 rld busy set", v, 2);
    idle(8); rd(3, v); chk("R11 rld busy clear", v, 0);
  endtask

  task automatic t_period(int p, int r, string tag);
    int iv;
    do_reset();
    if (p != 0 || r != 12'hFFF) setup(p, r);
    wr(0, 16'hCCCC);
    measure(iv);
    chk(tag, iv, period(p, r));
  endtask

  task automatic t_width();
    int v;
    do_reset(); setup(0, 1); wr(0, 16'hCCCC);
    v = width_err; idle(200);
    chk("R7 pulse width", width_err - v, 0);
  endtask

  task automatic t_feed();
    int v;
    do_reset(); setup(1, 3); wr(0, 16'hCCCC);
    v = npulse;
    for (int i = 0; i < 12; i++) begin idle(36); wr(0, 16'hAAAA); end
    chk("R8 refresh prevents expiry", npulse - v, 0);
    idle(period(1, 3) + 4);
    chk("R8 expiry after refresh stops", (npulse - v) > 0, 1);
  endtask

  task automatic t_nostop();
    int iv;
    do_reset(); setup(0, 3); wr(0, 16'hCCCC);
    wr(0, 16'h0000); wr(0, 16'h5555); wr(0, 16'hFFFF);
    measure(iv);
    chk("R9 cannot stop", iv, period(0, 3));
  endtask

  task automatic t_debug();
    int v, iv;
    do_reset(); setup(0, 3); wr(0, 16'hCCCC);
    @(negedge clk); dbg_hold = 1; cpu_halted = 1;
    v = npulse; idle(400);
    chk("R10 frozen no pulse", npulse - v, 0);
    cpu_halted = 0;
    idle(period(0, 3) + 4);
    chk("R10 resumes after halt", (npulse - v) > 0, 1);
    measure(iv);
    chk("R10 hold alone no effect", iv, period(0, 3));
  endtask

  initial begin
    t_reset();
    t_locks();
    t_busy();
    t_period(0, 3, "R6 psc0 rld3");
    t_period(2, 1, "R6 psc2 rld1");
    t_period(7, 0, "R6 psc7 saturates");
    t_period(0, 12'hFFF, "R6 reset config R4 load");
    t_width();
    t_feed();
    t_nostop();
    t_debug();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule